// File: doc/BRIEF.md
# DRAM Device-Side Cycle Decoder

This block is the control front end of an asynchronous page-mode DRAM, rebuilt as synchronous logic. A fast internal clock samples the four active-low strobes: row strobe, column strobe, write enable and output enable. The block works out what kind of memory cycle the host is running from the order in which the strobe edges arrive. It latches row and column addresses and runs the read and write accesses into a small internal cell array. It keeps the internal refresh row counter and manages the extended-data-out behaviour of the 4-bit data port, where read data stays on the port after the column strobe rises.

The decoder recognises these cycles:
- read
- early write
- delayed write
- row-strobe-only refresh
- counter refresh, where the column strobe is already low
- hidden refresh, where the column strobe is held low across a read
- test-entry cycle

In test mode, column bit 0 selects nothing. Writes fill both cells of a pair, and reads return a per-bit compare of the pair. A debug output reports the last classified cycle. Two further outputs expose the refresh counter and the row most recently refreshed.

Top module: `dram_cycle_decoder`

## Requirements
- R1: After reset, the class output is 0, the refresh counter is 0, the last refreshed row is 0, test mode is off and the data port is not driven.
- R2: A falling row strobe with the column strobe high latches the row from addr_i. A falling column strobe with write enable high then reads the word at {row bits [2:0], addr_i bits [2:0]} and sets the class to 1. dq_oe_o is 1 while output enable is low.
- R3: Read data stays on dq_o, still enabled, after the column strobe rises while the row strobe is low. Every further column-strobe fall inside the same row-strobe-low period is a new access.
- R4: The output turns off on an output-enable rising edge, on any write-enable falling edge, or once both row and column strobes are high (the later of the two rises). It stays off until the next read access.
- R5: Write enable low at the column-strobe fall is an early write. The class becomes 2, dq_i is stored, and the output stays off.
- R6: Write enable falling while the column strobe is low, after a read access, is a delayed write. The class becomes 3 and dq_i is stored at that access's column.
- R7: A row-strobe low period with no column-strobe fall sets the class to 4 at the row-strobe rise. The full 10-bit latched row is reported as the refreshed row. The counter is unchanged and test mode ends.
- R8: Column strobe low (in the same or an earlier sample) when the row strobe falls, with write enable high, is a counter refresh. The class becomes 5 and the refreshed row is the old counter value. The counter adds 1, wrapping from 1023 to 0, and test mode ends.
- R9: A hidden refresh keeps the column strobe low from a read through a row-strobe rise and fall. It behaves as R8, while dq_o and dq_oe_o keep the read data.
- R10: Column strobe and write enable both low at the row-strobe fall enters test mode. The class becomes 6 and the counter adds 1.
- R11: In test mode, column bit 0 is ignored. A write stores dq_i in both cells of the pair, and a read returns the bitwise XOR of the pair, so matching bits read 0.
- R12: The class output keeps its last value until another cycle is classified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| row_strobe_ni | input | 1 | Row address strobe, active low |
| col_strobe_ni | input | 1 | Column address strobe, active low |
| wr_en_ni | input | 1 | Write enable, active low |
| out_en_ni | input | 1 | Output enable, active low |
| addr_i | input | 10 | Multiplexed row/column address |
| dq_i | input | 4 | Write data |
| dq_o | output | 4 | Read data |
| dq_oe_o | output | 1 | Data port drive enable |
| cls_o | output | 3 | Last cycle class (0 idle, 1 read, 2 early write, 3 delayed write, 4 row-only refresh, 5 counter refresh, 6 test entry) |
| rfsh_cnt_o | output | 10 | Internal refresh row counter |
| rfsh_row_o | output | 10 | Row most recently refreshed |
| test_mode_o | output | 1 | Test mode active |

## Verification
If the strobe-order state is wrong, cls_o shows the wrong class one clock after the edge that should have decided it. A wrong read also appears on dq_o or dq_oe_o in that same clock. A stale or lost output-valid flag shows up on dq_oe_o one clock after an output-enable rise, a write-enable fall or the two strobes both being high. It also shows when the column strobe rises during a page or a hidden refresh. A counter fault is visible on rfsh_cnt_o one clock after any row-strobe fall. A full 1024-step sweep exposes wrap errors, and every cell is written and read back so that address slicing errors show.

// File: rtl/dcd_pkg.sv
`timescale 1ns/1ps
package dcd_pkg;
  typedef enum logic [2:0] {
    CLS_IDLE       = 3'd0,
    CLS_READ       = 3'd1,
    CLS_EWRITE     = 3'd2,
    CLS_DWRITE     = 3'd3,
    CLS_ROW_RFSH   = 3'd4,
    CLS_CNT_RFSH   = 3'd5,
    CLS_TEST_ENTRY = 3'd6
  } cls_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ROW,
    ST_PAGE,
    ST_RFSH
  } st_e;
endpackage

// File: rtl/dcd_strobe_edges.sv
`timescale 1ns/1ps
module dcd_strobe_edges (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic row_strobe_ni,
  input  logic col_strobe_ni,
  input  logic wr_en_ni,
  input  logic out_en_ni,
  output logic ras_fall_o,
  output logic ras_rise_o,
  output logic cas_fall_o,
  output logic we_fall_o,
  output logic oe_rise_o
);
  localparam int NSTB = 4;
  logic [NSTB-1:0] cur, prev_q;

  assign cur = {out_en_ni, wr_en_ni, col_strobe_ni, row_strobe_ni};

  // strobes idle high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '1;
    else         prev_q <= cur;
  end

  assign ras_fall_o = prev_q[0] & ~cur[0];
  assign ras_rise_o = ~prev_q[0] & cur[0];
  assign cas_fall_o = prev_q[1] & ~cur[1];
  assign we_fall_o  = prev_q[2] & ~cur[2];
  assign oe_rise_o  = ~prev_q[3] & cur[3];
endmodule

// File: rtl/dcd_cycle_fsm.sv
`timescale 1ns/1ps
module dcd_cycle_fsm
  import dcd_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int CNT_W  = 10,
  parameter int MCOL_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              col_strobe_ni,
  input  logic              wr_en_ni,
  input  logic              ras_fall_i,
  input  logic              ras_rise_i,
  input  logic              cas_fall_i,
  input  logic              we_fall_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output cls_e              cls_o,
  output logic              test_o,
  output logic              rd_stb_o,
  output logic              wr_stb_o,
  output logic              cnt_inc_o,
  output logic [ADDR_W-1:0] row_o,
  output logic [MCOL_W-1:0] col_o,
  output logic [ADDR_W-1:0] rfsh_row_o
);
  st_e               st_q, st_d;
  cls_e              cls_q, cls_d;
  logic              test_q, test_d;
  logic              dly_ok_q, dly_ok_d;
  logic [ADDR_W-1:0] row_q, row_d;
  logic [MCOL_W-1:0] col_q, col_d;
  logic [ADDR_W-1:0] rfsh_row_q, rfsh_row_d;

  always_comb begin
    st_d       = st_q;
    cls_d      = cls_q;
    test_d     = test_q;
    dly_ok_d   = dly_ok_q;
    row_d      = row_q;
    col_d      = col_q;
    rfsh_row_d = rfsh_row_q;
    rd_stb_o   = 1'b0;
    wr_stb_o   = 1'b0;
    cnt_inc_o  = 1'b0;
    col_o      = addr_i[MCOL_W-1:0];
    case (st_q)
      ST_IDLE: begin
        if (ras_fall_i) begin
          if (!col_strobe_ni) begin
            // column strobe first: refresh from internal counter
            st_d       = ST_RFSH;
            cnt_inc_o  = 1'b1;
            rfsh_row_d = ADDR_W'(cnt_i);
            if (!wr_en_ni) begin
              cls_d  = CLS_TEST_ENTRY;
              test_d = 1'b1;
            end else begin
              cls_d  = CLS_CNT_RFSH;
              test_d = 1'b0;
            end
          end else begin
            st_d  = ST_ROW;
            row_d = addr_i;
          end
        end
      end
      ST_ROW, ST_PAGE: begin
        if (ras_rise_i) begin
          st_d = ST_IDLE;
          if (st_q == ST_ROW) begin
            cls_d      = CLS_ROW_RFSH;
            test_d     = 1'b0;
            rfsh_row_d = row_q;
          end
        end else if (cas_fall_i) begin
          st_d  = ST_PAGE;
          col_d = addr_i[MCOL_W-1:0];
          if (wr_en_ni) begin
            rd_stb_o = 1'b1;
            cls_d    = CLS_READ;
            dly_ok_d = 1'b1;
          end else begin
            wr_stb_o = 1'b1;
            cls_d    = CLS_EWRITE;
            dly_ok_d = 1'b0;
          end
        end else if (st_q == ST_PAGE && we_fall_i && !col_strobe_ni && dly_ok_q) begin
          wr_stb_o = 1'b1;
          col_o    = col_q;
          cls_d    = CLS_DWRITE;
          dly_ok_d = 1'b0;
        end
      end
      ST_RFSH: begin
        if (ras_rise_i) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      cls_q      <= CLS_IDLE;
      test_q     <= 1'b0;
      dly_ok_q   <= 1'b0;
      row_q      <= '0;
      col_q      <= '0;
      rfsh_row_q <= '0;
    end else begin
      st_q       <= st_d;
      cls_q      <= cls_d;
      test_q     <= test_d;
      dly_ok_q   <= dly_ok_d;
      row_q      <= row_d;
      col_q      <= col_d;
      rfsh_row_q <= rfsh_row_d;
    end
  end

  assign cls_o      = cls_q;
  assign test_o     = test_q;
  assign row_o      = row_q;
  assign rfsh_row_o = rfsh_row_q;
endmodule

// File: rtl/dcd_refresh_ctr.sv
`timescale 1ns/1ps
module dcd_refresh_ctr #(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  // wraps at 2**CNT_W
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/dcd_cell_array.sv
`timescale 1ns/1ps
module dcd_cell_array #(
  parameter int DATA_W = 4,
  parameter int MROW_W = 3,
  parameter int MCOL_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              test_i,
  input  logic              wr_i,
  input  logic [MROW_W-1:0] row_i,
  input  logic [MCOL_W-1:0] col_i,
  input  logic [DATA_W-1:0] wd_i,
  output logic [DATA_W-1:0] rd_o
);
  localparam int IDX_W = MROW_W + MCOL_W;
  localparam int DEPTH = 1 << IDX_W;

  logic [IDX_W-1:0]              idx;
  logic [IDX_W-2:0]              pair;
  logic [DEPTH-1:0][DATA_W-1:0]  words;

  assign idx  = {row_i, col_i};
  assign pair = idx[IDX_W-1:1];

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    localparam logic [IDX_W-1:0] WI = IDX_W'(w);
    logic              hit;
    logic [DATA_W-1:0] word_q;

    // test mode: column bit 0 ignored, pair written together
    assign hit = test_i ? (pair == WI[IDX_W-1:1]) : (idx == WI);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         word_q <= '0;
      else if (wr_i && hit) word_q <= wd_i;
    end

    assign words[w] = word_q;
  end

  assign rd_o = test_i ? (words[{pair, 1'b0}] ^ words[{pair, 1'b1}]) : words[idx];
endmodule

// File: rtl/dcd_edo_out.sv
`timescale 1ns/1ps
module dcd_edo_out #(
  parameter int DATA_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              clr_i,
  input  logic              out_en_ni,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o
);
  logic              valid_q;
  logic [DATA_W-1:0] data_q;

  // a new access wins over any clear in the same sample
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (load_i) begin
      valid_q <= 1'b1;
      data_q  <= load_data_i;
    end else if (clr_i) begin
      valid_q <= 1'b0;
    end
  end

  assign dq_o    = data_q;
  assign dq_oe_o = valid_q & ~out_en_ni;
endmodule

// File: rtl/dram_cycle_decoder.sv
`timescale 1ns/1ps
module dram_cycle_decoder
  import dcd_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 4,
  parameter int CNT_W  = 10,
  parameter int MROW_W = 3,
  parameter int MCOL_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              row_strobe_ni,
  input  logic              col_strobe_ni,
  input  logic              wr_en_ni,
  input  logic              out_en_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o,
  output logic [2:0]        cls_o,
  output logic [CNT_W-1:0]  rfsh_cnt_o,
  output logic [ADDR_W-1:0] rfsh_row_o,
  output logic              test_mode_o
);
  logic              ras_fall, ras_rise, cas_fall, we_fall, oe_rise;
  logic              rd_stb, wr_stb, cnt_inc, test_mode, out_clr;
  cls_e              cls;
  logic [ADDR_W-1:0] row;
  logic [MCOL_W-1:0] col;
  logic [DATA_W-1:0] rd_data;

  dcd_strobe_edges u_edges (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .row_strobe_ni(row_strobe_ni),
    .col_strobe_ni(col_strobe_ni),
    .wr_en_ni     (wr_en_ni),
    .out_en_ni    (out_en_ni),
    .ras_fall_o   (ras_fall),
    .ras_rise_o   (ras_rise),
    .cas_fall_o   (cas_fall),
    .we_fall_o    (we_fall),
    .oe_rise_o    (oe_rise)
  );

  dcd_cycle_fsm #(
    .ADDR_W(ADDR_W),
    .CNT_W (CNT_W),
    .MCOL_W(MCOL_W)
  ) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .col_strobe_ni(col_strobe_ni),
    .wr_en_ni     (wr_en_ni),
    .ras_fall_i   (ras_fall),
    .ras_rise_i   (ras_rise),
    .cas_fall_i   (cas_fall),
    .we_fall_i    (we_fall),
    .addr_i       (addr_i),
    .cnt_i        (rfsh_cnt_o),
    .cls_o        (cls),
    .test_o       (test_mode),
    .rd_stb_o     (rd_stb),
    .wr_stb_o     (wr_stb),
    .cnt_inc_o    (cnt_inc),
    .row_o        (row),
    .col_o        (col),
    .rfsh_row_o   (rfsh_row_o)
  );

  dcd_refresh_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (cnt_inc),
    .cnt_o (rfsh_cnt_o)
  );

  dcd_cell_array #(
    .DATA_W(DATA_W),
    .MROW_W(MROW_W),
    .MCOL_W(MCOL_W)
  ) u_array (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .test_i(test_mode),
    .wr_i  (wr_stb),
    .row_i (row[MROW_W-1:0]),
    .col_i (col),
    .wd_i  (dq_i),
    .rd_o  (rd_data)
  );

  // output off: OE rise, WE fall, or both strobes high
  assign out_clr = wr_stb | we_fall | oe_rise | (row_strobe_ni & col_strobe_ni);

  dcd_edo_out #(.DATA_W(DATA_W)) u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (rd_stb),
    .load_data_i(rd_data),
    .clr_i      (out_clr),
    .out_en_ni  (out_en_ni),
    .dq_o       (dq_o),
    .dq_oe_o    (dq_oe_o)
  );

  assign cls_o       = cls;
  assign test_mode_o = test_mode;
endmodule

// File: rtl/dcd_checker.sv
`timescale 1ns/1ps
module dcd_checker #(
  parameter int CNT_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             row_strobe_ni,
  input logic             col_strobe_ni,
  input logic             out_en_ni,
  input logic             dq_oe_o,
  input logic [2:0]       cls_o,
  input logic [CNT_W-1:0] rfsh_cnt_o,
  input logic             test_mode_o
);
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(row_strobe_ni) && !col_strobe_ni) |=> (rfsh_cnt_o == $past(rfsh_cnt_o) + 1'b1)); // R8

  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !($fell(row_strobe_ni) && !col_strobe_ni) |=> $stable(rfsh_cnt_o)); // R7

  AST_EWR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cls_o == 3'd2 && !row_strobe_ni && !col_strobe_ni) |-> !dq_oe_o); // R5

  AST_BOTH_HIGH_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_strobe_ni && col_strobe_ni) |=> !dq_oe_o); // R4

  AST_OE_RISE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(out_en_ni) && !$fell(col_strobe_ni)) |=> !dq_oe_o); // R4

  AST_TEST_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cls_o == 3'd4 || cls_o == 3'd5) |-> !test_mode_o); // R7

  AST_TEST_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cls_o == 3'd6) |-> test_mode_o); // R10
endmodule

bind dram_cycle_decoder dcd_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .row_strobe_ni(row_strobe_ni),
  .col_strobe_ni(col_strobe_ni),
  .out_en_ni    (out_en_ni),
  .dq_oe_o      (dq_oe_o),
  .cls_o        (cls_o),
  .rfsh_cnt_o   (rfsh_cnt_o),
  .test_mode_o  (test_mode_o)
);

// File: tb/dram_cycle_decoder_tb.sv
`timescale 1ns/1ps
module dram_cycle_decoder_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ras, cas, we, oe;
  logic [9:0] addr;
  logic [3:0] din;
  logic [3:0] dout;
  logic       doe;
  logic [2:0] cls;
  logic [9:0] cnt;
  logic [9:0] rrow;
  logic       tm;

  int         n_chk  = 0;
  int         n_fail = 0;
  bit         done   = 1'b0;
  logic [3:0] exp_mem [64];
  logic [9:0] exp_cnt;

  always #5 clk = ~clk;

  dram_cycle_decoder u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .row_strobe_ni(ras),
    .col_strobe_ni(cas),
    .wr_en_ni     (we),
    .out_en_ni    (oe),
    .addr_i       (addr),
    .dq_i         (din),
    .dq_o         (dout),
    .dq_oe_o      (doe),
    .cls_o        (cls),
    .rfsh_cnt_o   (cnt),
    .rfsh_row_o   (rrow),
    .test_mode_o  (tm)
  );

  task automatic drv(input logic r, input logic c, input logic w, input logic o,
                     input logic [9:0] a, input logic [3:0] d);
    @(negedge clk);
    ras = r; cas = c; we = w; oe = o; addr = a; din = d;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] pat(input int r, input int c);
    return 4'(r * 5 + c * 3 + 7);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    ras = 1; cas = 1; we = 1; oe = 1; addr = '0; din = '0; rst_n = 1'b0;
    exp_cnt = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk);
    #1;
    chk("R1 cls", cls, 0);
    chk("R1 cnt", cnt, 0);
    chk("R1 oe", doe, 0);
    chk("R1 test", tm, 0);
    chk("R1 row", rrow, 0);

    // R5: early write over every cell, one page per row
    for (int r = 0; r < 8; r++) begin
      drv(0, 1, 1, 0, 10'(r), 0);
      for (int c = 0; c < 8; c++) begin
        drv(0, 1, 0, 0, 10'(c), pat(r, c));
        drv(0, 0, 0, 0, 10'(c), pat(r, c));
        chk("R5 cls", cls, 2);
        chk("R5 oe off", doe, 0);
        exp_mem[r * 8 + c] = pat(r, c);
        drv(0, 1, 1, 0, 10'(c), 0);
      end
      drv(1, 1, 1, 0, 0, 0);
    end

    // R2 R3: page reads with EDO hold
    for (int r = 0; r < 8; r++) begin
      drv(0, 1, 1, 0, 10'(r), 0);
      for (int c = 0; c < 8; c++) begin
        drv(0, 0, 1, 0, 10'(c), 0);
        chk("R2 cls", cls, 1);
        chk("R2 oe", doe, 1);
        chk("R2 data", dout, exp_mem[r * 8 + c]);
        drv(0, 1, 1, 0, 10'(c), 0);
        chk("R3 hold oe", doe, 1);
        chk("R3 hold data", dout, exp_mem[r * 8 + c]);
      end
      drv(1, 1, 1, 0, 0, 0);
      chk("R4 both high", doe, 0);
    end

    // R4: OE rising edge
    drv(0, 1, 1, 0, 1, 0);
    drv(0, 0, 1, 0, 2, 0);
    chk("R4 pre oe", doe, 1);
    drv(0, 0, 1, 1, 2, 0);
    chk("R4 oe high", doe, 0);
    drv(0, 0, 1, 0, 2, 0);
    chk("R4 oe stays off", doe, 0);
    drv(0, 1, 1, 0, 0, 0);
    drv(1, 1, 1, 0, 0, 0);

    // R4: WE fall with CAS high
    drv(0, 1, 1, 0, 1, 0);
    drv(0, 0, 1, 0, 3, 0);
    drv(0, 1, 1, 0, 3, 0);
    chk("R3 hold before we", doe, 1);
    drv(0, 1, 0, 0, 3, 0);
    chk("R4 we fall", doe, 0);
    drv(0, 1, 1, 0, 3, 0);
    chk("R4 we stays off", doe, 0);
    drv(1, 1, 1, 0, 0, 0);

    // R4: later of the two rises turns off
    drv(0, 1, 1, 0, 1, 0);
    drv(0, 0, 1, 0, 4, 0);
    drv(1, 0, 1, 0, 0, 0);
    chk("R4 ras rise cas low", doe, 1);
    drv(1, 1, 1, 0, 0, 0);
    chk("R4 cas rise last", doe, 0);

    // R6: delayed write
    drv(0, 1, 1, 1, 2, 0);
    drv(0, 0, 1, 1, 5, 0);
    chk("R6 read first", cls, 1);
    drv(0, 0, 0, 1, 5, 4'hA);
    chk("R6 cls", cls, 3);
    exp_mem[2 * 8 + 5] = 4'hA;
    drv(0, 1, 1, 1, 5, 0);
    drv(1, 1, 1, 1, 0, 0);
    repeat (3) drv(1, 1, 1, 1, 0, 0);
    chk("R12 cls held", cls, 3);
    drv(0, 1, 1, 0, 2, 0);
    drv(0, 0, 1, 0, 5, 0);
    chk("R6 readback", dout, 4'hA);
    drv(0, 1, 1, 0, 0, 0);
    drv(1, 1, 1, 0, 0, 0);

    // R7: row-only refresh
    for (int i = 0; i < 3; i++) begin
      logic [9:0] ra;
      ra = (i == 0) ? 10'h2A5 : (i == 1) ? 10'h3FF : 10'h001;
      drv(0, 1, 1, 1, ra, 0);
      drv(1, 1, 1, 1, 0, 0);
      chk("R7 cls", cls, 4);
      chk("R7 row", rrow, ra);
      chk("R7 cnt", cnt, exp_cnt);
    end

    // R9: hidden refresh
    drv(0, 1, 1, 0, 3, 0);
    drv(0, 0, 1, 0, 4, 0);
    chk("R9 read", dout, exp_mem[3 * 8 + 4]);
    drv(1, 0, 1, 0, 0, 0);
    chk("R9 oe after ras rise", doe, 1);
    drv(0, 0, 1, 0, 0, 0);
    chk("R9 cls", cls, 5);
    chk("R9 row", rrow, exp_cnt);
    exp_cnt++;
    chk("R9 cnt", cnt, exp_cnt);
    chk("R9 oe", doe, 1);
    chk("R9 data", dout, exp_mem[3 * 8 + 4]);
    drv(1, 0, 1, 0, 0, 0);
    drv(1, 1, 1, 0, 0, 0);
    chk("R9 off at end", doe, 0);

    // R10 R11: test mode
    drv(1, 0, 0, 1, 0, 0);
    drv(0, 0, 0, 1, 0, 0);
    chk("R10 cls", cls, 6);
    chk("R10 test", tm, 1);
    exp_cnt++;
    chk("R10 cnt", cnt, exp_cnt);
    drv(1, 0, 0, 1, 0, 0);
    drv(1, 1, 1, 1, 0, 0);
    drv(0, 1, 1, 1, 4, 0);
    drv(0, 1, 0, 1, 2, 4'h9);
    drv(0, 0, 0, 1, 2, 4'h9);
    exp_mem[4 * 8 + 2] = 4'h9;
    exp_mem[4 * 8 + 3] = 4'h9;
    drv(0, 1, 1, 1, 0, 0);
    drv(1, 1, 1, 1, 0, 0);
    drv(0, 1, 1, 0, 4, 0);
    drv(0, 0, 1, 0, 3, 0);
    chk("R11 match low", dout, exp_mem[34] ^ exp_mem[35]);
    chk("R11 oe", doe, 1);
    drv(0, 1, 1, 0, 0, 0);
    drv(1, 1, 1, 0, 0, 0);
    drv(0, 1, 1, 1, 4, 0);
    drv(1, 1, 1, 1, 0, 0);
    chk("R7 test exit", tm, 0);
    chk("R7 exit cls", cls, 4);
    drv(0, 1, 1, 1, 4, 0);
    drv(0, 1, 0, 1, 3, 4'h5);
    drv(0, 0, 0, 1, 3, 4'h5);
    exp_mem[4 * 8 + 3] = 4'h5;
    drv(0, 1, 1, 1, 0, 0);
    drv(1, 1, 1, 1, 0, 0);
    drv(1, 0, 0, 1, 0, 0);
    drv(0, 0, 0, 1, 0, 0);
    exp_cnt++;
    chk("R10 reenter", tm, 1);
    drv(1, 0, 0, 1, 0, 0);
    drv(1, 1, 1, 1, 0, 0);
    drv(0, 1, 1, 0, 4, 0);
    drv(0, 0, 1, 0, 2, 0);
    chk("R11 mismatch", dout, exp_mem[34] ^ exp_mem[35]);
    drv(0, 1, 1, 0, 0, 0);
    drv(1, 1, 1, 0, 0, 0);
    drv(1, 0, 1, 1, 0, 0);
    drv(0, 0, 1, 1, 0, 0);
    exp_cnt++;
    chk("R8 test exit", tm, 0);
    chk("R8 exit cls", cls, 5);
    drv(1, 0, 1, 1, 0, 0);
    drv(1, 1, 1, 1, 0, 0);
    drv(0, 1, 1, 0, 4, 0);
    drv(0, 0, 1, 0, 2, 0);
    chk("R11 normal col bit0", dout, 4'h9);
    drv(0, 1, 1, 0, 0, 0);
    drv(1, 1, 1, 0, 0, 0);

    // R8: same-sample fall counts as CAS first
    drv(0, 0, 1, 1, 0, 0);
    chk("R8 same sample cls", cls, 5);
    chk("R8 same sample row", rrow, exp_cnt);
    exp_cnt++;
    chk("R8 same sample cnt", cnt, exp_cnt);
    drv(1, 1, 1, 1, 0, 0);

    // R8: full counter sweep with wrap
    begin
      logic [9:0] start;
      start = exp_cnt;
      for (int i = 0; i < 1024; i++) begin
        drv(1, 0, 1, 1, 0, 0);
        drv(0, 0, 1, 1, 0, 0);
        chk("R8 row", rrow, exp_cnt);
        exp_cnt++;
        chk("R8 cnt", cnt, exp_cnt);
        drv(1, 0, 1, 1, 0, 0);
        drv(1, 1, 1, 1, 0, 0);
      end
      chk("R8 wrap", cnt, start);
      chk("R8 cls", cls, 5);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule